// File: doc/BRIEF.md
# Sector Controller Host Register Bank

This block is the register file that a host processor uses to program and watch a CD sector controller. The host sees one 8-bit data port and a 4-bit register index. Every read or write acts on the register that the index selects, and the index then moves on by one. The host can therefore load the index once and stream through a group of registers. Reads and writes use different maps at the same index.

The bank holds the interface-control, control-0 and control-1 registers. It holds the byte count, the data address, the write address and the block pointer, plus two 4-byte header banks. It derives status bytes 0, 2 and 3 from these registers, and it keeps an interface-status byte whose interrupt flags are active low. From those flags it produces a registered, level-style interrupt request.

Two strobe inputs connect the block to its neighbours. A decoder event loads a header bank. A transfer-end event closes a data transfer. A pulse output starts the transfer engine, and the byte count and data address are driven out to that engine.

Top module: `dctl_regbank`

## Requirements
- R1: A host access (write, or read with no write) at index 1 to 14 leaves the index at the old value plus one. An access at index 0 leaves it at 0. A cycle with `host_idx_ld` high loads `host_idx` and performs no access.
- R2: A read at index 0 returns 0xFF, and a write at index 0 changes no register.
- R3: The read map is: 1 interface status; 2/3 byte count low/high; 4..7 header bytes 0..3, where byte k is `dec_hdr[8k+7:8k]`; 8/9 block pointer low/high; 10/11 write address low/high; 12 status 0; 13 constant 0x00; 14 status 2; 15 status 3.
- R4: The write map is: 1 interface control; 2/3 byte count low/high; 4/5 data address low/high, seen on `data_addr`; 6 transfer trigger; 7 transfer acknowledge; 8/9 write address; 10 control 0; 11 control 1; 12/13 block pointer; 14 ignored; 15 soft reset.
- R5: Header reads come from bank 1 when control-1 bit 0 is 1, and from bank 0 otherwise.
- R6: A write to control 0 sets status 0 to bit 7 of the written byte. Status 2 equals control 1 AND 0x08 when control-0 bit 4 is 1, and control 1 AND 0x0C otherwise. Status 2 is recomputed on a write to either control register.
- R7: A read at index 15 returns status 3. After the read, status 3 is 0x80, interface-status bit 5 is 1, and the index is 0.
- R8: A write to interface control sets the interrupt pending state if (written bit 6 and status bit 6 == 0) or (written bit 5 and status bit 5 == 0), and clears it otherwise. `irq` is the registered AND of the pending state and `irq_lvl_en`.
- R9: After hardware reset, or after a write at index 15, interface status is 0xFF, status 3 is 0x80, header bank 0 reads 00 00 00 01, all other registers are 0, the index is 0, and `irq` is 0.
- R10: A decoder event while control-0 bit 7 is 1 loads `dec_hdr` into the bank chosen by `dec_bank`, sets status 3 to 0x00, clears status bit 5, and sets the pending state if control bit 5 is 1. With control-0 bit 7 at 0, the event has no effect.
- R11: A trigger write while interface-control bit 1 is 1 clears status bit 3, clears byte-count bits 15:12, and pulses `xfer_go` for one cycle. A trigger write with bit 1 at 0 does nothing. An interface-control write with bit 1 at 0 sets status bits 3 and 1. An acknowledge write sets status bit 6 and clears byte-count bits 15:12.
- R12: A transfer-end event sets status bits 3 and 1, clears bit 6, loads the byte count with 0xF000, and sets the pending state if control bit 6 is 1.
- R13: When a strobe and a host access fall in the same cycle, the strobe's effect wins over the access on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx_ld | input | 1 | Load the register index |
| host_idx | input | 4 | Index value to load |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data at the current index (combinational) |
| cur_idx | output | 4 | Current register index |
| dec_evt | input | 1 | Decoder header event |
| dec_bank | input | 1 | Header bank for the decoder event |
| dec_hdr | input | 32 | Header bytes, byte 0 in the low bits |
| xfer_end | input | 1 | Transfer-end event from the transfer engine |
| irq_lvl_en | input | 1 | External interrupt level enable |
| irq | output | 1 | Registered interrupt request |
| xfer_go | output | 1 | One-cycle transfer start pulse |
| byte_cnt | output | 16 | Byte count register |
| data_addr | output | 16 | Data address register |

## Verification
Two collisions matter most. A decoder event can arrive in the same cycle as the host read of status 3. A transfer-end event can arrive in the same cycle as an acknowledge write. The bench forces both by raising the strobe during the access cycle. In the first case the read must return the old 0x80, and afterwards status 3 must read 0x00 with the decoder flag still pending. In the second case the transfer-end flag must stay low.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
    localparam int DW    = 8;
    localparam int IW    = 4;
    localparam int HB    = 4;
    localparam int NBANK = 2;
    localparam int CW    = 2 * DW;
    localparam int HW    = HB * DW;

    // interface status / control bit positions
    localparam int B_END  = 6;
    localparam int B_DEC  = 5;
    localparam int B_BUSY = 3;
    localparam int B_RDY  = 1;
    localparam int B_OE   = 1;
    // control bits
    localparam int C0_DECEN = 7;
    localparam int C0_AUTO  = 4;
    localparam int C1_HSEL  = 0;

    // write map
    localparam logic [IW-1:0] W_IFC = 4'd1, W_CNTL = 4'd2, W_CNTH = 4'd3,
        W_DAL = 4'd4, W_DAH = 4'd5, W_TRG = 4'd6, W_ACK = 4'd7,
        W_WAL = 4'd8, W_WAH = 4'd9, W_C0 = 4'd10, W_C1 = 4'd11,
        W_PTL = 4'd12, W_PTH = 4'd13, W_SRST = 4'd15;

    localparam logic [HW-1:0] HDR0_INIT = 32'h0100_0000;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } hacc_t;

    function automatic logic [DW-1:0] mode_stat(input logic [DW-1:0] c0,
                                                input logic [DW-1:0] c1);
        return c0[C0_AUTO] ? (c1 & 8'h08) : (c1 & 8'h0C);
    endfunction
endpackage

// File: rtl/dctl_index.sv
module dctl_index
    import dctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [IW-1:0] ld_val,
    input  logic          acc,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = {IW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (ld)
            idx <= ld_val;
        else if (acc) begin
            if (idx == LAST)
                idx <= '0;
            else if (idx != '0)
                idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/dctl_intr.sv
module dctl_intr
    import dctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ifc_wr,
    input  logic [DW-1:0] ifc_data,
    input  logic [DW-1:0] ifctrl_q,
    input  logic          trig_ok,
    input  logic          ack_wr,
    input  logic          st3_rd,
    input  logic          dec_fire,
    input  logic          end_fire,
    input  logic          lvl_en,
    output logic [DW-1:0] ifstat,
    output logic          irq
);
    logic          pend, pend_n;
    logic [DW-1:0] ifs_n, en;

    always_comb begin
        ifs_n  = ifstat;
        pend_n = pend;
        en     = ifc_wr ? ifc_data : ifctrl_q;
        if (ifc_wr) begin
            pend_n = (ifc_data[B_END] & ~ifstat[B_END]) |
                     (ifc_data[B_DEC] & ~ifstat[B_DEC]);
            if (!ifc_data[B_OE]) begin
                ifs_n[B_BUSY] = 1'b1;
                ifs_n[B_RDY]  = 1'b1;
            end
        end
        if (trig_ok) ifs_n[B_BUSY] = 1'b0;
        if (ack_wr)  ifs_n[B_END]  = 1'b1;
        if (st3_rd)  ifs_n[B_DEC]  = 1'b1;
        // strobes last: they win over host effects
        if (dec_fire) begin
            ifs_n[B_DEC] = 1'b0;
            if (en[B_DEC]) pend_n = 1'b1;
        end
        if (end_fire) begin
            ifs_n[B_BUSY] = 1'b1;
            ifs_n[B_RDY]  = 1'b1;
            ifs_n[B_END]  = 1'b0;
            if (en[B_END]) pend_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ifstat <= '1;
            pend   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            ifstat <= ifs_n;
            pend   <= pend_n;
            irq    <= pend_n & lvl_en;
        end
    end
endmodule

// File: rtl/dctl_rdmux.sv
module dctl_rdmux
    import dctl_pkg::*;
(
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] ifstat,
    input  logic [CW-1:0] cnt,
    input  logic [HW-1:0] hdr,
    input  logic [CW-1:0] ptr,
    input  logic [CW-1:0] wad,
    input  logic [DW-1:0] st0,
    input  logic [DW-1:0] st2,
    input  logic [DW-1:0] st3,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (idx)
            4'd1:  rdata = ifstat;
            4'd2:  rdata = cnt[DW-1:0];
            4'd3:  rdata = cnt[CW-1:DW];
            4'd4:  rdata = hdr[0*DW +: DW];
            4'd5:  rdata = hdr[1*DW +: DW];
            4'd6:  rdata = hdr[2*DW +: DW];
            4'd7:  rdata = hdr[3*DW +: DW];
            4'd8:  rdata = ptr[DW-1:0];
            4'd9:  rdata = ptr[CW-1:DW];
            4'd10: rdata = wad[DW-1:0];
            4'd11: rdata = wad[CW-1:DW];
            4'd12: rdata = st0;
            4'd13: rdata = '0;
            4'd14: rdata = st2;
            4'd15: rdata = st3;
            default: rdata = '1;
        endcase
    end
endmodule

// File: rtl/dctl_regbank.sv
module dctl_regbank
    import dctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_idx_ld,
    input  logic [IW-1:0] host_idx,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [IW-1:0] cur_idx,
    input  logic          dec_evt,
    input  logic          dec_bank,
    input  logic [HW-1:0] dec_hdr,
    input  logic          xfer_end,
    input  logic          irq_lvl_en,
    output logic          irq,
    output logic          xfer_go,
    output logic [CW-1:0] byte_cnt,
    output logic [CW-1:0] data_addr
);
    hacc_t         acc;
    logic          wr_ok, rd_ok, srst, rst_all;
    logic          trig_ok, dec_fire, rd_st3;
    logic [DW-1:0] ifctrl, ctrl0, ctrl1, st0, st2, st3, ifstat;
    logic [CW-1:0] wad, ptr;
    logic [HW-1:0] hdr [NBANK];

    always_comb begin
        acc.wr   = host_wr & ~host_idx_ld;
        acc.rd   = host_rd & ~host_wr & ~host_idx_ld;
        acc.idx  = cur_idx;
        acc.data = host_wdata;
    end

    assign wr_ok    = acc.wr;
    assign rd_ok    = acc.rd;
    assign srst     = wr_ok && acc.idx == W_SRST;
    assign rst_all  = rst | srst;
    assign trig_ok  = wr_ok && acc.idx == W_TRG && ifctrl[B_OE];
    assign dec_fire = dec_evt & ctrl0[C0_DECEN];
    assign rd_st3   = rd_ok && acc.idx == 4'd15;

    dctl_index u_idx (
        .clk(clk), .rst(rst), .ld(host_idx_ld), .ld_val(host_idx),
        .acc(wr_ok | rd_ok), .idx(cur_idx)
    );

    dctl_intr u_intr (
        .clk(clk), .rst(rst_all),
        .ifc_wr(wr_ok && acc.idx == W_IFC), .ifc_data(acc.data),
        .ifctrl_q(ifctrl), .trig_ok(trig_ok),
        .ack_wr(wr_ok && acc.idx == W_ACK), .st3_rd(rd_st3),
        .dec_fire(dec_fire), .end_fire(xfer_end), .lvl_en(irq_lvl_en),
        .ifstat(ifstat), .irq(irq)
    );

    // control registers and derived status
    always_ff @(posedge clk) begin
        if (rst_all) begin
            ifctrl <= '0; ctrl0 <= '0; ctrl1 <= '0;
            st0 <= '0; st2 <= '0; st3 <= 8'h80;
            wad <= '0; ptr <= '0; data_addr <= '0; xfer_go <= 1'b0;
        end else begin
            xfer_go <= trig_ok;
            if (wr_ok) begin
                unique case (acc.idx)
                    W_IFC: ifctrl <= acc.data;
                    W_DAL: data_addr[DW-1:0]  <= acc.data;
                    W_DAH: data_addr[CW-1:DW] <= acc.data;
                    W_WAL: wad[DW-1:0]  <= acc.data;
                    W_WAH: wad[CW-1:DW] <= acc.data;
                    W_PTL: ptr[DW-1:0]  <= acc.data;
                    W_PTH: ptr[CW-1:DW] <= acc.data;
                    W_C0: begin
                        ctrl0 <= acc.data;
                        st0   <= acc.data & 8'h80;
                        st2   <= mode_stat(acc.data, ctrl1);
                    end
                    W_C1: begin
                        ctrl1 <= acc.data;
                        st2   <= mode_stat(ctrl0, acc.data);
                    end
                    default: ;
                endcase
            end
            if (dec_fire)    st3 <= 8'h00;
            else if (rd_st3) st3 <= 8'h80;
        end
    end

    // byte count: host bytes, nibble clears, then transfer end wins
    always_ff @(posedge clk) begin
        if (rst_all)
            byte_cnt <= '0;
        else if (xfer_end)
            byte_cnt <= 16'hF000;
        else begin
            if (wr_ok && acc.idx == W_CNTL) byte_cnt[DW-1:0]  <= acc.data;
            if (wr_ok && acc.idx == W_CNTH) byte_cnt[CW-1:DW] <= acc.data;
            if (trig_ok || (wr_ok && acc.idx == W_ACK))
                byte_cnt[CW-1:CW-4] <= 4'h0;
        end
    end

    // header banks
    for (genvar b = 0; b < NBANK; b++) begin : g_hdr
        localparam logic [HW-1:0] INIT = (b == 0) ? HDR0_INIT : '0;
        always_ff @(posedge clk) begin
            if (rst_all)
                hdr[b] <= INIT;
            else if (dec_fire && dec_bank == b[0])
                hdr[b] <= dec_hdr;
        end
    end

    dctl_rdmux u_rd (
        .idx(cur_idx), .ifstat(ifstat), .cnt(byte_cnt),
        .hdr(hdr[ctrl1[C1_HSEL]]), .ptr(ptr), .wad(wad),
        .st0(st0), .st2(st2), .st3(st3), .rdata(host_rdata)
    );
endmodule

// File: rtl/dctl_regbank_chk.sv
module dctl_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_idx_ld,
    input logic        host_wr,
    input logic        host_rd,
    input logic [3:0]  cur_idx,
    input logic        xfer_end,
    input logic        irq_lvl_en,
    input logic        irq,
    input logic        xfer_go,
    input logic [15:0] byte_cnt
);
    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && !host_idx_ld && cur_idx != 4'd0 && cur_idx != 4'd15)
        |=> cur_idx == $past(cur_idx) + 4'd1);

    // R2
    idx_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && !host_idx_ld && cur_idx == 4'd0) |=> cur_idx == 4'd0);

    // R7
    last_read_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && !host_idx_ld && cur_idx == 4'd15) |=> cur_idx == 4'd0);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_lvl_en |=> !irq);

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_idx_ld && cur_idx == 4'd15 && !xfer_end)
        |=> (!irq && byte_cnt == 16'h0000 && cur_idx == 4'd0));

    // R11
    go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_go |=> !xfer_go);

    // R12
    end_count_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> byte_cnt == 16'hF000);
endmodule

bind dctl_regbank dctl_regbank_chk u_chk (
    .clk(clk), .rst(rst), .host_idx_ld(host_idx_ld), .host_wr(host_wr),
    .host_rd(host_rd), .cur_idx(cur_idx), .xfer_end(xfer_end),
    .irq_lvl_en(irq_lvl_en), .irq(irq), .xfer_go(xfer_go), .byte_cnt(byte_cnt)
);

// File: tb/dctl_regbank_test.sv
module dctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_idx_ld = 0, host_wr = 0, host_rd = 0;
    logic [3:0]  host_idx = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic [3:0]  cur_idx;
    logic        dec_evt = 0, dec_bank = 0, xfer_end = 0, irq_lvl_en = 0;
    logic [31:0] dec_hdr = 0;
    logic        irq, xfer_go;
    logic [15:0] byte_cnt, data_addr;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dctl_regbank uut (.*);

    function automatic logic [7:0] exp_st2(input logic [7:0] c0, input logic [7:0] c1);
        return c0[4] ? (c1 & 8'h08) : (c1 & 8'h0C);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic ld_idx(input logic [3:0] i);
        host_idx_ld = 1; host_idx = i;
        @(negedge clk);
        host_idx_ld = 0;
    endtask

    task automatic wr_seq(input logic [7:0] v);
        host_wr = 1; host_wdata = v;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd_seq(output logic [7:0] d);
        host_rd = 1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic wr_reg(input logic [3:0] i, input logic [7:0] v);
        ld_idx(i); wr_seq(v);
    endtask

    task automatic rd_reg(input logic [3:0] i, output logic [7:0] d);
        ld_idx(i); rd_seq(d);
    endtask

    task automatic pulse_dec(input logic bank, input logic [31:0] h);
        dec_evt = 1; dec_bank = bank; dec_hdr = h;
        @(negedge clk);
        dec_evt = 0;
    endtask

    task automatic pulse_end();
        xfer_end = 1;
        @(negedge clk);
        xfer_end = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] c0, c1, a, b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R9 reset state
        chk("R9 idx", cur_idx, 0);
        chk("R9 irq", irq, 0);
        rd_reg(1, d);  chk("R9 ifstat", d, 8'hFF);
        rd_reg(15, d); chk("R9 stat3", d, 8'h80);
        rd_reg(4, d);  chk("R9 hdr0", d, 8'h00);
        rd_seq(d);     chk("R9 hdr1", d, 8'h00);
        rd_seq(d);     chk("R9 hdr2", d, 8'h00);
        rd_seq(d);     chk("R9 hdr3", d, 8'h01);
        chk("R1 idx after 4 reads", cur_idx, 8);

        // R2 index 0
        wr_reg(0, 8'h5A); chk("R2 idx hold", cur_idx, 0);
        rd_seq(d);        chk("R2 read 0", d, 8'hFF);
        chk("R2 idx hold rd", cur_idx, 0);

        // R10 ignored while decoding off
        pulse_dec(0, 32'hDEADBEEF);
        rd_reg(1, d);  chk("R10 off ifstat", d, 8'hFF);
        rd_reg(15, d); chk("R10 off stat3", d, 8'h80);
        rd_reg(7, d);  chk("R10 off hdr", d, 8'h01);

        // R6 random control writes
        for (int k = 0; k < 40; k++) begin
            c0 = 8'($urandom); c1 = 8'($urandom);
            if (k == 0) begin c0 = 8'h10; c1 = 8'hFF; end
            if (k == 1) begin c0 = 8'h80; c1 = 8'hFF; end
            wr_reg(10, c0); wr_seq(c1);
            chk("R1 idx after ctrl", cur_idx, 12);
            rd_reg(12, d); chk("R6 stat0", d, c0 & 8'h80);
            rd_seq(d);     chk("R3 idx13 zero", d, 8'h00);
            rd_seq(d);     chk("R6 stat2", d, exp_st2(c0, c1));
            // control 1 write alone recomputes
            c1 = 8'($urandom);
            wr_reg(11, c1);
            rd_reg(14, d); chk("R6 stat2 c1", d, exp_st2(c0, c1));
        end
        wr_reg(10, 8'h00); wr_seq(8'h00);

        // R4 / R3 readback of counters
        for (int k = 0; k < 20; k++) begin
            a = 8'($urandom); b = 8'($urandom);
            wr_reg(2, a); wr_seq(b);
            rd_reg(2, d); chk("R3 cnt lo", d, a);
            rd_seq(d);    chk("R3 cnt hi", d, b);
            chk("R4 byte_cnt", byte_cnt, {b, a});
            wr_reg(8, a); wr_seq(b);
            rd_reg(10, d); chk("R3 wa lo", d, a);
            rd_seq(d);     chk("R3 wa hi", d, b);
            wr_reg(12, b); wr_seq(a);
            rd_reg(8, d); chk("R3 pt lo", d, b);
            rd_seq(d);    chk("R3 pt hi", d, a);
            wr_reg(4, a); wr_seq(b);
            chk("R4 data_addr", data_addr, {b, a});
        end

        // R4 index 14 ignored
        wr_reg(10, 8'h00); wr_seq(8'h0C);
        wr_reg(14, 8'hFF); chk("R4 idx14 step", cur_idx, 15);
        rd_reg(14, d);     chk("R4 idx14 ignored", d, 8'h0C);

        // R10 decoder events, R5 bank select
        irq_lvl_en = 1;
        wr_reg(10, 8'h80); wr_seq(8'h00);
        wr_reg(1, 8'h20);  chk("R8 no pending", irq, 0);
        pulse_dec(0, 32'h44332211);
        chk("R10 irq", irq, 1);
        rd_reg(1, d);  chk("R10 ifstat", d, 8'hDF);
        rd_reg(4, d);  chk("R10 h0", d, 8'h11);
        rd_seq(d);     chk("R10 h1", d, 8'h22);
        rd_seq(d);     chk("R10 h2", d, 8'h33);
        rd_seq(d);     chk("R10 h3", d, 8'h44);
        pulse_dec(1, 32'hDDCCBBAA);
        wr_reg(11, 8'h01);
        rd_reg(4, d);  chk("R5 bank1 h0", d, 8'hAA);
        rd_reg(7, d);  chk("R5 bank1 h3", d, 8'hDD);
        wr_reg(11, 8'h00);
        rd_reg(7, d);  chk("R5 bank0 h3", d, 8'h44);
        rd_reg(15, d); chk("R7 stat3", d, 8'h00);
        chk("R7 idx zero", cur_idx, 0);
        rd_reg(15, d); chk("R7 stat3 set", d, 8'h80);
        rd_reg(1, d);  chk("R7 ifstat bit5", d, 8'hFF);
        chk("R8 irq held", irq, 1);
        wr_reg(1, 8'h00); chk("R8 clear", irq, 0);

        // R8 level gate
        pulse_dec(0, 32'h0);
        irq_lvl_en = 0;
        wr_reg(1, 8'h20); chk("R8 gated", irq, 0);
        irq_lvl_en = 1;
        @(negedge clk);   chk("R8 ungated", irq, 1);
        wr_reg(1, 8'h40); chk("R8 wrong flag", irq, 0);
        rd_reg(15, d);

        // R13 decoder event against status-3 read
        ld_idx(15);
        host_rd = 1; dec_evt = 1; dec_hdr = 32'h0;
        #1 chk("R13 old stat3", host_rdata, 8'h80);
        @(negedge clk);
        host_rd = 0; dec_evt = 0;
        rd_reg(1, d);  chk("R13 dec pending", d, 8'hDF);
        rd_reg(15, d); chk("R13 stat3", d, 8'h00);

        // R11 / R12 transfer
        wr_reg(1, 8'h42); chk("R8 idle", irq, 0);
        wr_reg(2, 8'h23); wr_seq(8'hF1);
        wr_reg(6, 8'h00); chk("R11 go", xfer_go, 1);
        rd_reg(1, d);     chk("R11 busy", d, 8'hF7);
        chk("R11 go pulse", xfer_go, 0);
        rd_reg(3, d);     chk("R11 nibble", d, 8'h01);
        pulse_end();
        chk("R12 irq", irq, 1);
        chk("R12 cnt", byte_cnt, 16'hF000);
        rd_reg(1, d);     chk("R12 ifstat", d, 8'hBF);
        wr_reg(7, 8'h00);
        rd_reg(1, d);     chk("R11 ack", d, 8'hFF);
        chk("R11 ack cnt", byte_cnt, 16'h0000);
        wr_reg(1, 8'h00); chk("R8 clr", irq, 0);
        wr_reg(6, 8'h00); chk("R11 no go", xfer_go, 0);
        rd_reg(1, d);     chk("R11 no busy", d, 8'hFF);

        // R13 transfer end against acknowledge
        ld_idx(7);
        host_wr = 1; xfer_end = 1;
        @(negedge clk);
        host_wr = 0; xfer_end = 0;
        rd_reg(1, d);     chk("R13 end wins", d, 8'hBF);
        wr_reg(7, 8'h00);
        rd_reg(1, d);     chk("R13 ack after", d, 8'hFF);

        // R9 soft reset
        wr_reg(10, 8'h90); wr_seq(8'h0F);
        wr_reg(2, 8'h34);
        pulse_dec(0, 32'h12345678);
        wr_reg(1, 8'h20);
        wr_reg(15, 8'h00);
        chk("R9 srst idx", cur_idx, 0);
        chk("R9 srst irq", irq, 0);
        chk("R9 srst cnt", byte_cnt, 0);
        rd_reg(1, d);  chk("R9 srst ifstat", d, 8'hFF);
        rd_reg(7, d);  chk("R9 srst hdr3", d, 8'h01);
        rd_reg(12, d); chk("R9 srst stat0", d, 8'h00);
        rd_seq(d);     rd_seq(d); chk("R9 srst stat2", d, 8'h00);
        rd_seq(d);     chk("R9 srst stat3", d, 8'h80);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule